// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator Mixer

This block turns four phase-accumulator voices into one stereo stream of 8-bit unsigned samples. Every voice owns a 24-bit phase and a 24-bit increment, both in 9.15 fixed point. On each accepted sample tick the block advances every phase by its increment, modulo 2^24, and stores the result. It then uses the nine integer bits of the new phase to pick one byte from an external 1024-byte waveform table. The four bytes are averaged, and the average drives the left and right outputs alike.

The host reaches the voice registers one byte at a time through a 32-byte window. A surrounding decoder places this window so that voice n's phase word sits at window offset 8n and its increment word at 8n+4. Each word is big-endian, and its top byte always reads as zero. The two lower voices share the lower 512-byte half of the table, and the two upper voices share the upper half. The four table lookups are spread over successive cycles through a single read port, and a one-cycle valid pulse marks each finished sample.

Top module: `wavemix_top`

## Requirements
- R1: After reset, sampleL and sampleR read 0x80, sampleValid is low, and every register byte reads 0.
- R2: Register byte address a selects voice a[4:3], with a[2]=0 for the phase and a[2]=1 for the increment. Byte lane a[1:0]=0 is bits 31:24, lane 1 bits 23:16, lane 2 bits 15:8 and lane 3 bits 7:0. Lane 0 always reads 0, and a write to it has no effect.
- R3: Each accepted tick replaces every phase with (phase + increment) mod 2^24, and the new value is readable afterwards.
- R4: After the edge that accepts a tick, tblAddr presents {voice[1], newPhase[23:15]} for voices 0, 1, 2 and 3 in turn, one per cycle, on the four following edges. tblData is taken on the edge after its address appears.
- R5: The sample equals (sum of the four table bytes) >> 2, and the same value appears on sampleL and sampleR.
- R6: sampleValid is high for exactly one cycle, starting at the fifth edge after the edge that accepts the tick. The new sample appears at that same edge.
- R7: A tick arriving while a sample is in progress is ignored. It causes no extra pulse and no extra phase step.
- R8: A tick is accepted only while mode equals 2. When mode is any other value, ticks are ignored, the phases stay unchanged, and a sample in progress is abandoned without a valid pulse.
- R9: sampleL and sampleR keep their value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode; 2 enables wavetable generation |
| sampleTick | input | 1 | Request for one output sample |
| regWr | input | 1 | Host byte write strobe |
| regAddr | input | 5 | Host byte address inside the voice register window |
| regWrData | input | 8 | Host write byte |
| regRdData | output | 8 | Host read byte (combinational from regAddr) |
| tblAddr | output | 10 | Waveform table byte address |
| tblData | input | 8 | Waveform table byte for tblAddr |
| sampleL | output | 8 | Left output sample |
| sampleR | output | 8 | Right output sample |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The checks take for granted that the waveform table answers tblAddr within the same cycle. They also assume that mode changes only on purpose and that the host does not write a voice register while a sample is being computed, because a phase step takes priority over a host write to the same phase. The stimulus writes registers only while the block is idle. It changes mode only in the directed tests that probe abandonment, and it drives every input at the falling edge, so the table model settles before the rising edge that samples it.

// File: rtl/wavemix_pkg.sv
package wavemix_pkg;

  localparam logic [1:0] MODE_WAVE = 2'd2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic stepEn;   // advance the selected voice and issue its table read
    logic accClr;   // clear the byte accumulator
    logic accEn;    // add the byte fetched for the previous voice
    logic outLoad;  // add the last byte and load the averaged sample
  } wavemixStb_t;

endpackage

// File: rtl/wavemix_ctrl.sv
module wavemix_ctrl
  import wavemix_pkg::*;
#(
  parameter int VOICES = 4,
  localparam int VSEL_W = $clog2(VOICES),
  localparam int STEP_W = $clog2(VOICES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              sampleTick,
  output wavemixStb_t       stb,
  output logic [VSEL_W-1:0] voiceSel
);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t   stateQ;
  logic [STEP_W-1:0] stepQ;
  logic        waveOn;
  logic        lastStep;

  assign waveOn   = (mode == MODE_WAVE);
  assign lastStep = (stepQ == STEP_W'(VOICES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
    end else if (!waveOn) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (sampleTick) begin
            stateQ <= ST_RUN;
            stepQ  <= '0;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            stateQ <= ST_IDLE;
            stepQ  <= '0;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    voiceSel = stepQ[VSEL_W-1:0];
    if (waveOn) begin
      if (stateQ == ST_IDLE) begin
        stb.accClr = sampleTick;
      end else if (!lastStep) begin
        stb.stepEn = 1'b1;
        stb.accEn  = (stepQ != '0);
      end else begin
        stb.outLoad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wavemix_dp.sv
module wavemix_dp
  import wavemix_pkg::*;
#(
  parameter int VOICES   = 4,
  parameter int PHASE_W  = 24,
  parameter int FRAC_W   = 15,
  parameter int SAMPLE_W = 8,
  parameter int TBL_AW   = 10,
  localparam int VSEL_W   = $clog2(VOICES),
  localparam int REG_AW   = VSEL_W + 3,
  localparam int IDX_W    = PHASE_W - FRAC_W,
  localparam int REGION_W = TBL_AW - IDX_W,
  localparam int ACC_W    = SAMPLE_W + VSEL_W,
  localparam int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wavemixStb_t         stb,
  input  logic [VSEL_W-1:0]   voiceSel,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic [TBL_AW-1:0]   tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  output logic [SAMPLE_W-1:0] sampleL,
  output logic [SAMPLE_W-1:0] sampleR,
  output logic                sampleValid
);

  // place one host byte into a big-endian 32-bit view of a register
  function automatic logic [PHASE_W-1:0] mergeByte(
    input logic [PHASE_W-1:0] old,
    input logic [1:0]         lane,
    input logic [7:0]         b
  );
    logic [WORD_W-1:0] w;
    int sh;
    w  = WORD_W'(old);
    sh = 8 * (3 - int'(lane));
    w[sh +: 8] = b;
    return w[PHASE_W-1:0];
  endfunction

  logic [VOICES-1:0][PHASE_W-1:0] phaseAll;
  logic [VOICES-1:0][PHASE_W-1:0] incAll;
  logic [PHASE_W-1:0] nextPhase;
  logic [VSEL_W-1:0]  hostVoice;
  logic [1:0]         hostLane;
  logic               hostIsInc;

  assign hostVoice = regAddr[REG_AW-1:3];
  assign hostIsInc = regAddr[2];
  assign hostLane  = regAddr[1:0];

  // modulo 2^PHASE_W step of the selected voice
  assign nextPhase = phaseAll[voiceSel] + incAll[voiceSel];

  for (genvar v = 0; v < VOICES; v++) begin : gVoice
    logic [PHASE_W-1:0] phaseR;
    logic [PHASE_W-1:0] incR;
    logic hostHit;
    logic stepHit;

    assign hostHit = regWr && (hostVoice == VSEL_W'(v));
    assign stepHit = stb.stepEn && (voiceSel == VSEL_W'(v));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phaseR <= '0;
        incR   <= '0;
      end else begin
        if (stepHit) begin
          phaseR <= nextPhase;
        end else if (hostHit && !hostIsInc) begin
          phaseR <= mergeByte(phaseR, hostLane, regWrData);
        end
        if (hostHit && hostIsInc) begin
          incR <= mergeByte(incR, hostLane, regWrData);
        end
      end
    end

    assign phaseAll[v] = phaseR;
    assign incAll[v]   = incR;
  end

  // host read path
  logic [WORD_W-1:0] rdWord;
  always_comb begin
    int sh;
    rdWord    = hostIsInc ? WORD_W'(incAll[hostVoice]) : WORD_W'(phaseAll[hostVoice]);
    sh        = 8 * (3 - int'(hostLane));
    regRdData = rdWord[sh +: 8];
  end

  // table address: voice group picks the table region, phase integer bits the byte
  logic [TBL_AW-1:0]   tblAddrQ;
  logic [REGION_W-1:0] region;
  assign region = voiceSel[VSEL_W-1 -: REGION_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblAddrQ <= '0;
    end else if (stb.stepEn) begin
      tblAddrQ <= {region, nextPhase[PHASE_W-1 -: IDX_W]};
    end
  end
  assign tblAddr = tblAddrQ;

  // mixing: sum the voice bytes, average by shifting out the voice count
  logic [ACC_W-1:0]    accQ;
  logic [ACC_W-1:0]    accSum;
  logic [SAMPLE_W-1:0] sampleLQ;
  logic [SAMPLE_W-1:0] sampleRQ;
  logic                validQ;

  assign accSum = accQ + ACC_W'(tblData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (stb.accClr) begin
      accQ <= '0;
    end else if (stb.accEn) begin
      accQ <= accSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleLQ <= {1'b1, {(SAMPLE_W-1){1'b0}}};
      sampleRQ <= {1'b1, {(SAMPLE_W-1){1'b0}}};
      validQ   <= 1'b0;
    end else begin
      validQ <= stb.outLoad;
      if (stb.outLoad) begin
        sampleLQ <= accSum[ACC_W-1 -: SAMPLE_W];
        sampleRQ <= accSum[ACC_W-1 -: SAMPLE_W];
      end
    end
  end

  assign sampleL     = sampleLQ;
  assign sampleR     = sampleRQ;
  assign sampleValid = validQ;

endmodule

// File: rtl/wavemix_top.sv
module wavemix_top
  import wavemix_pkg::*;
#(
  parameter int VOICES   = 4,
  parameter int PHASE_W  = 24,
  parameter int FRAC_W   = 15,
  parameter int SAMPLE_W = 8,
  parameter int TBL_AW   = 10,
  localparam int VSEL_W  = $clog2(VOICES),
  localparam int REG_AW  = VSEL_W + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          mode,
  input  logic                sampleTick,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic [TBL_AW-1:0]   tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  output logic [SAMPLE_W-1:0] sampleL,
  output logic [SAMPLE_W-1:0] sampleR,
  output logic                sampleValid
);

  wavemixStb_t       stb;
  logic [VSEL_W-1:0] voiceSel;

  wavemix_ctrl #(
    .VOICES(VOICES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .sampleTick(sampleTick),
    .stb       (stb),
    .voiceSel  (voiceSel)
  );

  wavemix_dp #(
    .VOICES  (VOICES),
    .PHASE_W (PHASE_W),
    .FRAC_W  (FRAC_W),
    .SAMPLE_W(SAMPLE_W),
    .TBL_AW  (TBL_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .voiceSel   (voiceSel),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .sampleL    (sampleL),
    .sampleR    (sampleR),
    .sampleValid(sampleValid)
  );

endmodule

// File: rtl/wavemix_checker.sv
module wavemix_checker
  import wavemix_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       sampleTick,
  input logic       sampleValid,
  input logic [7:0] sampleL,
  input logic [7:0] sampleR,
  input logic [4:0] regAddr,
  input logic [7:0] regRdData
);

  // independent count of cycles since a tick was accepted
  logic [2:0] chkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt <= '0;
    end else if (mode != MODE_WAVE) begin
      chkCnt <= '0;
    end else if (chkCnt == 3'd0 || chkCnt == 3'd6) begin
      chkCnt <= sampleTick ? 3'd1 : 3'd0;
    end else begin
      chkCnt <= chkCnt + 3'd1;
    end
  end

  // R6, R7: a pulse only at the fixed latency after an accepted tick
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (chkCnt == 3'd6));

  // R6: every accepted tick that kept its mode ends in a pulse
  a_r6_completes: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == 3'd6) |-> sampleValid);

  // R6: the pulse lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8: no pulse follows a cycle spent outside wavetable mode
  a_r8_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_WAVE) |=> !sampleValid);

  // R9: outputs move only together with a pulse
  a_r9_hold_left: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleL));

  a_r9_hold_right: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleR));

  // R2: the top byte of every 24-bit register reads zero
  a_r2_top_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] == 2'd0) |-> (regRdData == 8'd0));

endmodule

bind wavemix_top wavemix_checker u_wavemix_checker (
  .clk        (clk),
  .rstN       (rstN),
  .mode       (mode),
  .sampleTick (sampleTick),
  .sampleValid(sampleValid),
  .sampleL    (sampleL),
  .sampleR    (sampleR),
  .regAddr    (regAddr),
  .regRdData  (regRdData)
);

// File: tb/wavemix_top_bench.sv
module wavemix_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  // stimulus vectors: phase and increment per voice
  localparam logic [23:0] VEC_PH [NV][4] = '{
    '{24'h000000, 24'h000000, 24'h000000, 24'h000000},
    '{24'h000000, 24'h001000, 24'h100000, 24'h7F0000},
    '{24'hFFFFFF, 24'hFF8000, 24'h800000, 24'hFFFF00},
    '{24'h123456, 24'h654321, 24'h0ABCDE, 24'hFEDCBA},
    '{24'h3FFFFF, 24'h000000, 24'hC00000, 24'h555555},
    '{24'h7FFF00, 24'hABCDEF, 24'h00FFFF, 24'hF00000}
  };
  localparam logic [23:0] VEC_INC [NV][4] = '{
    '{24'h000000, 24'h000000, 24'h000000, 24'h000000},
    '{24'h008000, 24'h010000, 24'h000001, 24'h00FFFF},
    '{24'h000001, 24'h008000, 24'h7FFFFF, 24'h000100},
    '{24'h111111, 24'h222222, 24'h333333, 24'h444444},
    '{24'hFFFFFF, 24'hFFFFFF, 24'h400000, 24'h0AAAAA},
    '{24'h000100, 24'h800000, 24'hFFFFFF, 24'h123456}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       sampleTick = 1'b0;
  logic       regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [9:0] tblAddr;
  logic [7:0] tblData;
  logic [7:0] sampleL;
  logic [7:0] sampleR;
  logic       sampleValid;

  int checks = 0;
  int fails = 0;
  logic [23:0] curPh [4];
  logic [23:0] curInc [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] tblByte(input logic [9:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd37 + 16'(a >> 3) * 16'd11 + 16'd5;
    return t[7:0] ^ {a[9], 7'd0};
  endfunction

  always_comb tblData = tblByte(tblAddr);

  wavemix_top u_wavemix_top (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .sampleTick (sampleTick),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .sampleL    (sampleL),
    .sampleR    (sampleR),
    .sampleValid(sampleValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic write24(input int v, input bit isInc, input logic [23:0] val);
    for (int lane = 1; lane < 4; lane++) begin
      writeReg(5'(v * 8 + (isInc ? 4 : 0) + lane), val[8*(3-lane) +: 8]);
    end
  endtask

  task automatic read24(input int v, input bit isInc, output logic [23:0] val);
    logic [7:0] b;
    for (int lane = 1; lane < 4; lane++) begin
      readReg(5'(v * 8 + (isInc ? 4 : 0) + lane), b);
      val[8*(3-lane) +: 8] = b;
    end
  endtask

  task automatic setVoice(input int v, input logic [23:0] ph, input logic [23:0] inc);
    write24(v, 1'b0, ph);
    write24(v, 1'b1, inc);
    curPh[v]  = ph;
    curInc[v] = inc;
  endtask

  // one tick with full checking; reTick>=0 re-asserts the tick mid-sample
  task automatic runTick(input int reTick);
    logic [9:0]  expAddr [4];
    logic [9:0]  sum;
    logic [23:0] rb;
    int extra;
    sum = '0;
    for (int v = 0; v < 4; v++) begin
      curPh[v]   = curPh[v] + curInc[v];
      expAddr[v] = {1'(v >> 1), curPh[v][23:15]};
      sum        = sum + 10'(tblByte(expAddr[v]));
    end
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);            // accepting edge passed
    sampleTick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4", "table address", 32'(tblAddr), 32'(expAddr[k]));
      chk("R6", "valid low during lookups", 32'(sampleValid), 32'd0);
      sampleTick = (k == reTick);
    end
    @(negedge clk);
    sampleTick = 1'b0;
    chk("R6", "valid at fifth edge", 32'(sampleValid), 32'd1);
    chk("R5", "left sample", 32'(sampleL), 32'(sum[9:2]));
    chk("R5", "right sample", 32'(sampleR), 32'(sum[9:2]));
    extra = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (sampleValid) extra++;
    end
    chk("R7", "no further pulse", 32'(extra), 32'd0);
    chk("R9", "left held", 32'(sampleL), 32'(sum[9:2]));
    for (int v = 0; v < 4; v++) begin
      read24(v, 1'b0, rb);
      chk("R3", "phase readback", 32'(rb), 32'(curPh[v]));
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0]  b;
    logic [23:0] rb;
    int pulses;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "left at reset", 32'(sampleL), 32'h80);
    chk("R1", "right at reset", 32'(sampleR), 32'h80);
    chk("R1", "valid at reset", 32'(sampleValid), 32'd0);
    readReg(5'd9, b);
    chk("R1", "register at reset", 32'(b), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      curPh[v] = '0;
      curInc[v] = '0;
    end

    // R2: byte lanes, top lane ignored
    write24(1, 1'b0, 24'hA1B2C3);
    curPh[1] = 24'hA1B2C3;
    writeReg(5'd8, 8'hAB);
    readReg(5'd8, b);
    chk("R2", "top lane reads zero", 32'(b), 32'd0);
    readReg(5'd9, b);
    chk("R2", "lane 1 high byte", 32'(b), 32'hA1);
    readReg(5'd11, b);
    chk("R2", "lane 3 low byte", 32'(b), 32'hC3);
    write24(2, 1'b1, 24'h00FE01);
    curInc[2] = 24'h00FE01;
    read24(2, 1'b1, rb);
    chk("R2", "increment word", 32'(rb), 32'h00FE01);
    read24(2, 1'b0, rb);
    chk("R2", "phase untouched by increment write", 32'(rb), 32'd0);

    mode = 2'd2;
    // main table of vectors: two ticks each to show accumulation
    for (int n = 0; n < NV; n++) begin
      for (int v = 0; v < 4; v++) setVoice(v, VEC_PH[n][v], VEC_INC[n][v]);
      runTick(-1);
      runTick(-1);
    end

    // R7: a tick during a sample is ignored
    runTick(1);

    // R9: register writes without a tick leave the outputs alone
    b = sampleL;
    setVoice(0, 24'h7A0000, 24'h010000);
    chk("R9", "left held across writes", 32'(sampleL), 32'(b));
    chk("R9", "valid stays low", 32'(sampleValid), 32'd0);

    // R8: tick ignored in another mode
    mode = 2'd1;
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    pulses = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (sampleValid) pulses++;
    end
    chk("R8", "no pulse outside mode 2", 32'(pulses), 32'd0);
    read24(0, 1'b0, rb);
    chk("R8", "phase unchanged outside mode 2", 32'(rb), 32'h7A0000);

    // R8: leaving mode 2 mid-sample abandons it
    mode = 2'd2;
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    @(negedge clk);
    mode = 2'd0;
    pulses = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (sampleValid) pulses++;
    end
    chk("R8", "abandoned sample gives no pulse", 32'(pulses), 32'd0);

    // back to normal operation after abandonment
    mode = 2'd2;
    for (int v = 0; v < 4; v++) setVoice(v, 24'h040000 * 24'(v + 1), 24'h020000);
    runTick(-1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule